// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block turns one vector load or store command into a stream of element requests for a word-interleaved memory made of independent banks. A command carries a base word address, a two's-complement stride and an element count. The generator walks the addresses in element order and sends at most one request per cycle. A bank takes a request only when it has recovered from its previous access; until then the generator waits.

For loads, each bank returns a word a fixed number of cycles after the request. The block delays the element index by the same amount and writes the returned word into a vector register port, in element order. A one-cycle `done` pulse closes every command: after the last write-back for a load, after the last bank request for a store, and at once when the count is zero.

It sits between a vector instruction sequencer and the banked memory. The bank recovery time, the return latency, the bank count and the maximum vector length are all parameters.

Top module: `strided_vec_agu`

## Requirements
- R1: Request k of a command carries word address `base + k*stride` modulo 2^ADDR_W, with the stride read as a two's-complement value. `mem_we` equals the command's `op_store`.
- R2: `mem_bank` equals the low log2(NBANK) bits of `mem_addr`.
- R3: Two requests to the same bank are at least BUSY (4) cycles apart. A request goes out in the first cycle that its bank is free and the previous element has already gone.
- R4: Requests leave in strictly increasing element order, and `mem_elem` counts 0, 1, 2, ... within a command. A stalled element holds back every later element.
- R5: When the stride touches no bank twice within BUSY consecutive elements (for example stride 1, 5 or -3), the first request appears two cycles after `start` and one request follows every cycle after it, with no gap.
- R6: A stride of 0 or any multiple of NBANK places exactly BUSY cycles between consecutive requests.
- R7: For a load, the word presented on `mem_rdata` LAT (12) cycles after request k appears on `wb_data`, with `wb_idx` = k, in the cycle after that, and write-backs come in element order.
- R8: `done` is a single-cycle pulse. For a load it comes one cycle after the last write-back; for a store it comes one cycle after the last request.
- R9: A command with a count of zero raises `done` in the cycle after `start` and sends no memory request.
- R10: A `start` that arrives while `busy` is high is ignored, and the running command's addresses, count and direction do not change.
- R11: After reset, `busy`, `done`, `mem_req` and `wb_valid` are low. `busy` is high from the cycle after an accepted non-zero command until the cycle before `done`, and low while `done` is high.
- R12: A count larger than MAXVL (64) is clamped to MAXVL elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled when `busy` is low |
| op_store | input | 1 | 1 = store, 0 = load |
| base | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Two's-complement word distance between elements |
| vlen | input | clog2(MAXVL+1) | Element count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Bank request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_bank | output | clog2(NBANK) | Target bank |
| mem_elem | output | clog2(MAXVL) | Element index of the request |
| mem_rdata | input | DATA_W | Load word, valid LAT cycles after its request |
| wb_valid | output | 1 | Vector register write strobe |
| wb_idx | output | clog2(MAXVL) | Element index written |
| wb_data | output | DATA_W | Element data written |

## Verification
The bench builds the block with its defaults: 16 banks, a recovery time of 4, a return latency of 12, 64 elements and 32-bit addresses. With 16 banks, a stride of 8 alternates between two banks and stalls every other element, strides of 0 and 16 stay on one bank, and strides such as 1, 5 and -3 stream freely. A count of 100 in the 7-bit length field shows the clamp to 64. A latency of 12 keeps several loads in flight at once, so in-order write-back is tested under overlap. The bench predicts each request cycle with its own per-bank model and uses addresses that wrap past the top of the address space.

// File: rtl/vag_pkg.sv
package vag_pkg;

  // Direction of a vector memory command.
  typedef enum logic {
    VAG_LOAD  = 1'b0,
    VAG_STORE = 1'b1
  } vag_dir_e;

  // Default sizing shared by the modules of this block.
  localparam int unsigned VAG_NBANK  = 16;
  localparam int unsigned VAG_BUSY   = 4;
  localparam int unsigned VAG_LAT    = 12;
  localparam int unsigned VAG_MAXVL  = 64;
  localparam int unsigned VAG_ADDR_W = 32;
  localparam int unsigned VAG_DATA_W = 64;

endpackage

// File: rtl/vag_bank_timers.sv
module vag_bank_timers #(
  parameter int unsigned NBANK = 16,
  parameter int unsigned BUSY  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     issue_en,
  input  logic [$clog2(NBANK)-1:0] issue_bank,
  output logic [NBANK-1:0]         bank_free
);

  localparam int unsigned BANK_W = $clog2(NBANK);
  localparam int unsigned CNT_W  = (BUSY > 2) ? $clog2(BUSY) : 1;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit = issue_en && (issue_bank == BANK_W'(g));

    // Recovery counter: loaded on access, free again once it reaches zero.
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (hit) begin
        cnt <= CNT_W'(BUSY - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign bank_free[g] = (cnt == '0);

    // R3
    bank_recovery_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |-> !hit);
  end

endmodule

// File: rtl/vag_issue.sv
module vag_issue
  import vag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NBANK  = 16,
  parameter int unsigned MAXVL  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       op_store,
  input  logic [ADDR_W-1:0]          base,
  input  logic [ADDR_W-1:0]          stride,
  input  logic [$clog2(MAXVL+1)-1:0] vlen,
  input  logic [NBANK-1:0]           bank_free,
  input  logic                       op_done,
  output logic                       issue_en,
  output logic [$clog2(NBANK)-1:0]   issue_bank,
  output logic                       zero_now,
  output logic                       busy,
  output logic                       req_valid,
  output logic [ADDR_W-1:0]          req_addr,
  output logic [$clog2(NBANK)-1:0]   req_bank,
  output logic [$clog2(MAXVL)-1:0]   req_idx,
  output logic                       req_last,
  output logic                       req_store
);

  localparam int unsigned BANK_W = $clog2(NBANK);
  localparam int unsigned LEN_W  = $clog2(MAXVL + 1);
  localparam int unsigned IDX_W  = $clog2(MAXVL);

  logic               active;
  logic               busy_q;
  logic [ADDR_W-1:0]  cur_addr;
  logic [ADDR_W-1:0]  stride_q;
  logic [IDX_W-1:0]   cur_idx;
  logic [IDX_W-1:0]   last_idx;
  vag_dir_e           dir_q;
  logic [LEN_W-1:0]   vlen_eff;
  logic               accept;
  logic               at_last;

  // Counts above the register capacity are clamped.
  assign vlen_eff   = (vlen > LEN_W'(MAXVL)) ? LEN_W'(MAXVL) : vlen;
  assign accept     = start && !busy_q;
  assign zero_now   = accept && (vlen_eff == '0);
  assign issue_bank = cur_addr[BANK_W-1:0];
  assign issue_en   = active && bank_free[issue_bank];
  assign at_last    = (cur_idx == last_idx);
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      busy_q    <= 1'b0;
      cur_addr  <= '0;
      stride_q  <= '0;
      cur_idx   <= '0;
      last_idx  <= '0;
      dir_q     <= VAG_LOAD;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_bank  <= '0;
      req_idx   <= '0;
      req_last  <= 1'b0;
      req_store <= 1'b0;
    end else begin
      req_valid <= issue_en;
      if (issue_en) begin
        req_addr  <= cur_addr;
        req_bank  <= issue_bank;
        req_idx   <= cur_idx;
        req_last  <= at_last;
        req_store <= (dir_q == VAG_STORE);
        cur_addr  <= cur_addr + stride_q;
        cur_idx   <= cur_idx + 1'b1;
        if (at_last) begin
          active <= 1'b0;
        end
      end
      if (accept && !zero_now) begin
        active   <= 1'b1;
        busy_q   <= 1'b1;
        cur_addr <= base;
        stride_q <= stride;
        cur_idx  <= '0;
        last_idx <= IDX_W'(vlen_eff - LEN_W'(1));
        dir_q    <= op_store ? VAG_STORE : VAG_LOAD;
      end else if (op_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  // R4
  issue_order_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_last) |=> (!req_valid || (req_idx == IDX_W'($past(req_idx) + 1'b1))));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    zero_now |=> (!req_valid && !active));

  // R10
  active_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> busy_q);

endmodule

// File: rtl/vag_return.sv
module vag_return #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned LAT    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_last,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic              wb_last,
  output logic [DATA_W-1:0] wb_data
);

  // Stage k holds a load that went out k+1 cycles ago; the last stage
  // lines up with the cycle in which the bank presents its word.
  logic [LAT-1:0]   v_pipe;
  logic [LAT-1:0]   l_pipe;
  logic [IDX_W-1:0] i_pipe [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_pipe <= '0;
      l_pipe <= '0;
    end else begin
      v_pipe <= {v_pipe[LAT-2:0], ld_valid};
      l_pipe <= {l_pipe[LAT-2:0], ld_last};
    end
  end

  always_ff @(posedge clk) begin
    i_pipe[0] <= ld_idx;
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      i_pipe[g] <= i_pipe[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_last  <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= v_pipe[LAT-1];
      if (v_pipe[LAT-1]) begin
        wb_idx  <= i_pipe[LAT-1];
        wb_last <= l_pipe[LAT-1];
        wb_data <= mem_rdata;
      end
    end
  end

  // R7
  wb_order_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_last) |=> (!wb_valid || (wb_idx == IDX_W'($past(wb_idx) + 1'b1))));

endmodule

// File: rtl/strided_vec_agu.sv
module strided_vec_agu
  import vag_pkg::*;
#(
  parameter int unsigned ADDR_W = VAG_ADDR_W,
  parameter int unsigned DATA_W = VAG_DATA_W,
  parameter int unsigned NBANK  = VAG_NBANK,
  parameter int unsigned BUSY   = VAG_BUSY,
  parameter int unsigned LAT    = VAG_LAT,
  parameter int unsigned MAXVL  = VAG_MAXVL
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       op_store,
  input  logic [ADDR_W-1:0]          base,
  input  logic [ADDR_W-1:0]          stride,
  input  logic [$clog2(MAXVL+1)-1:0] vlen,
  output logic                       busy,
  output logic                       done,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [$clog2(NBANK)-1:0]   mem_bank,
  output logic [$clog2(MAXVL)-1:0]   mem_elem,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       wb_valid,
  output logic [$clog2(MAXVL)-1:0]   wb_idx,
  output logic [DATA_W-1:0]          wb_data
);

  localparam int unsigned BANK_W = $clog2(NBANK);
  localparam int unsigned IDX_W  = $clog2(MAXVL);

  logic [NBANK-1:0]  bank_free;
  logic              issue_en;
  logic [BANK_W-1:0] issue_bank;
  logic              zero_now;
  logic              req_last;
  logic              wb_last;
  logic              done_nxt;
  logic              done_q;

  vag_bank_timers #(
    .NBANK (NBANK),
    .BUSY  (BUSY)
  ) u_timers (
    .clk        (clk),
    .rst        (rst),
    .issue_en   (issue_en),
    .issue_bank (issue_bank),
    .bank_free  (bank_free)
  );

  vag_issue #(
    .ADDR_W (ADDR_W),
    .NBANK  (NBANK),
    .MAXVL  (MAXVL)
  ) u_issue (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_store   (op_store),
    .base       (base),
    .stride     (stride),
    .vlen       (vlen),
    .bank_free  (bank_free),
    .op_done    (done_nxt),
    .issue_en   (issue_en),
    .issue_bank (issue_bank),
    .zero_now   (zero_now),
    .busy       (busy),
    .req_valid  (mem_req),
    .req_addr   (mem_addr),
    .req_bank   (mem_bank),
    .req_idx    (mem_elem),
    .req_last   (req_last),
    .req_store  (mem_we)
  );

  vag_return #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .LAT    (LAT)
  ) u_return (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (mem_req && !mem_we),
    .ld_idx    (mem_elem),
    .ld_last   (req_last),
    .mem_rdata (mem_rdata),
    .wb_valid  (wb_valid),
    .wb_idx    (wb_idx),
    .wb_last   (wb_last),
    .wb_data   (wb_data)
  );

  // Completion: empty command, last store accepted, or last load written.
  assign done_nxt = zero_now
                  || (mem_req && mem_we && req_last)
                  || (wb_valid && wb_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_nxt;
    end
  end

  assign done = done_q;

  // R3
  back_to_back_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_bank != $past(mem_bank)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/tb_strided_vec_agu.sv
module tb_strided_vec_agu;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int NBANK  = 16;
  localparam int BUSY   = 4;
  localparam int LAT    = 12;
  localparam int MAXVL  = 64;
  localparam int LEN_W  = 7;
  localparam int IDX_W  = 6;
  localparam int WDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic              op_store;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] stride;
  logic [LEN_W-1:0]  vlen;
  logic              busy;
  logic              done;
  logic              mem_req;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        mem_bank;
  logic [IDX_W-1:0]  mem_elem;
  logic [DATA_W-1:0] mem_rdata;
  logic              wb_valid;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;

  always #2.5 clk = ~clk;

  strided_vec_agu dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_store  (op_store),
    .base      (base),
    .stride    (stride),
    .vlen      (vlen),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_bank  (mem_bank),
    .mem_elem  (mem_elem),
    .mem_rdata (mem_rdata),
    .wb_valid  (wb_valid),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data)
  );

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    return {a ^ 32'h5A5A_A5A5, a};
  endfunction

  // Banked memory: a load word shows up LAT cycles after its request.
  logic [DATA_W-1:0] slot [LAT];
  always @(posedge clk) begin
    slot[0] <= (mem_req && !mem_we) ? word_at(mem_addr) : '0;
    for (int k = 1; k < LAT; k++) slot[k] <= slot[k-1];
  end
  assign mem_rdata = slot[LAT-1];

  // Port monitor, sampled mid-cycle.
  int                rq_cyc  [128];
  logic [ADDR_W-1:0] rq_addr [128];
  logic [3:0]        rq_bank [128];
  int                rq_idx  [128];
  logic              rq_we   [128];
  int                wbk_cyc [128];
  int                wbk_idx [128];
  logic [DATA_W-1:0] wbk_dat [128];
  int                n_rq, n_wb, done_cnt, done_cyc;
  logic              busy_at_done;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && n_rq < 128) begin
        rq_cyc[n_rq]  = cyc;
        rq_addr[n_rq] = mem_addr;
        rq_bank[n_rq] = mem_bank;
        rq_idx[n_rq]  = int'(mem_elem);
        rq_we[n_rq]   = mem_we;
        n_rq++;
      end
      if (wb_valid && n_wb < 128) begin
        wbk_cyc[n_wb] = cyc;
        wbk_idx[n_wb] = int'(wb_idx);
        wbk_dat[n_wb] = wb_data;
        n_wb++;
      end
      if (done) begin
        done_cnt++;
        done_cyc     = cyc;
        busy_at_done = busy;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog expired act=%0d exp<=%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // One command; mode 1 = expect streaming, mode 2 = expect single bank.
  task automatic run_op(input string nm, input bit st, input logic [31:0] b,
                        input logic [31:0] s, input int vl, input int mode,
                        input bit interfere);
    int n;
    int S;
    int t;
    int exp_c [128];
    int last_use [16];
    logic [31:0] a;
    n = (vl > MAXVL) ? MAXVL : vl;
    n_rq = 0; n_wb = 0; done_cnt = 0;
    op_store = st; base = b; stride = s; vlen = LEN_W'(vl); start = 1'b1;
    S = cyc;
    step();
    start = 1'b0;
    chk(busy == (n > 0), "R11", {nm, " busy after start"}, busy, n > 0);
    if (interfere) begin
      step(); step();
      start = 1'b1; base = ~b; stride = s + 5; vlen = 7'd3; op_store = ~st;
      step();
      start = 1'b0;
    end
    for (int k = 0; k < 600 && done_cnt == 0; k++) step();
    repeat (24) step();

    // Independent issue-timing model from R3 and R4.
    for (int q = 0; q < 16; q++) last_use[q] = -100;
    t = S + 2;
    for (int i = 0; i < n; i++) begin
      a = b + s * 32'(i);
      exp_c[i] = (last_use[a[3:0]] + BUSY > t) ? last_use[a[3:0]] + BUSY : t;
      last_use[a[3:0]] = exp_c[i];
      t = exp_c[i] + 1;
    end

    chk(n_rq == n, (vl > MAXVL) ? "R12" : (n == 0 ? "R9" : "R1"),
        {nm, " request count"}, n_rq, n);
    for (int i = 0; i < n_rq && i < n; i++) begin
      a = b + s * 32'(i);
      chk(rq_addr[i] == a, "R1", {nm, " address"}, rq_addr[i], a);
      chk(rq_we[i] == st, "R1", {nm, " direction"}, rq_we[i], st);
      chk(rq_bank[i] == a[3:0], "R2", {nm, " bank"}, rq_bank[i], a[3:0]);
      chk(rq_idx[i] == i, "R4", {nm, " element order"}, rq_idx[i], i);
      chk(rq_cyc[i] == exp_c[i], "R3", {nm, " issue cycle"}, rq_cyc[i], exp_c[i]);
    end
    if (mode == 1 && n_rq == n && n > 0) begin
      chk(rq_cyc[0] == S + 2, "R5", {nm, " first request"}, rq_cyc[0], S + 2);
      chk(rq_cyc[n-1] - rq_cyc[0] == n - 1, "R5", {nm, " streaming span"},
          rq_cyc[n-1] - rq_cyc[0], n - 1);
    end
    if (mode == 2 && n_rq == n) begin
      for (int i = 1; i < n; i++)
        chk(rq_cyc[i] - rq_cyc[i-1] == BUSY, "R6", {nm, " single-bank gap"},
            rq_cyc[i] - rq_cyc[i-1], BUSY);
    end
    if (!st) begin
      chk(n_wb == n, "R7", {nm, " write-back count"}, n_wb, n);
      for (int i = 0; i < n_wb && i < n && i < n_rq; i++) begin
        a = b + s * 32'(i);
        chk(wbk_idx[i] == i, "R7", {nm, " write-back index"}, wbk_idx[i], i);
        chk(wbk_dat[i] == word_at(a), "R7", {nm, " write-back data"},
            wbk_dat[i], word_at(a));
        chk(wbk_cyc[i] == rq_cyc[i] + LAT + 1, "R7", {nm, " write-back cycle"},
            wbk_cyc[i], rq_cyc[i] + LAT + 1);
      end
    end else begin
      chk(n_wb == 0, "R7", {nm, " no write-back on store"}, n_wb, 0);
    end
    chk(done_cnt == 1, "R8", {nm, " done pulses"}, done_cnt, 1);
    if (n == 0) begin
      chk(done_cyc == S + 1, "R9", {nm, " empty done cycle"}, done_cyc, S + 1);
    end else if (st && n_rq == n) begin
      chk(done_cyc == rq_cyc[n-1] + 1, "R8", {nm, " store done cycle"},
          done_cyc, rq_cyc[n-1] + 1);
    end else if (!st && n_wb == n) begin
      chk(done_cyc == wbk_cyc[n-1] + 1, "R8", {nm, " load done cycle"},
          done_cyc, wbk_cyc[n-1] + 1);
    end
    chk(busy_at_done == 1'b0, "R11", {nm, " busy low at done"}, busy_at_done, 0);
    if (interfere)
      chk(n_rq == n && done_cnt == 1, "R10", {nm, " start while busy ignored"},
          n_rq, n);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; op_store = 1'b0; base = '0; stride = '0; vlen = '0;
    n_rq = 0; n_wb = 0; done_cnt = 0; busy_at_done = 1'b0; done_cyc = 0;
    repeat (4) step();
    rst = 1'b0;
    step();
    chk(!busy && !done, "R11", "reset busy/done", {busy, done}, 0);
    chk(!mem_req && !wb_valid, "R11", "reset mem_req/wb_valid", {mem_req, wb_valid}, 0);
  endtask

  task automatic t_unit_load();    run_op("unit load",     1'b0, 32'h100, 32'd1, 20, 1, 1'b0); endtask
  task automatic t_unit_store();   run_op("unit store",    1'b1, 32'h7,   32'd1, 64, 1, 1'b0); endtask
  task automatic t_stride16();     run_op("stride16 load", 1'b0, 32'h43,  32'd16, 5, 2, 1'b0); endtask
  task automatic t_stride0();      run_op("stride0 store", 1'b1, 32'h55,  32'd0,  4, 2, 1'b0); endtask
  task automatic t_stride8();      run_op("stride8 load",  1'b0, 32'h200, 32'd8,  6, 0, 1'b0); endtask
  task automatic t_negative();     run_op("neg store",     1'b1, 32'h20,  32'hFFFF_FFFD, 9, 1, 1'b0); endtask
  task automatic t_wrap();         run_op("wrap load",     1'b0, 32'hFFFF_FFF0, 32'd5, 8, 1, 1'b0); endtask
  task automatic t_zero();
    run_op("empty load",  1'b0, 32'h10, 32'd1, 0, 0, 1'b0);
    run_op("empty store", 1'b1, 32'h10, 32'd1, 0, 0, 1'b0);
  endtask
  task automatic t_clamp();        run_op("clamped store", 1'b1, 32'h300, 32'd1, 100, 1, 1'b0); endtask
  task automatic t_interfere();    run_op("busy restart",  1'b0, 32'h400, 32'd1, 10, 1, 1'b1); endtask

  initial begin
    t_reset();
    t_unit_load();
    t_unit_store();
    t_stride16();
    t_stride0();
    t_stride8();
    t_negative();
    t_wrap();
    t_zero();
    t_clamp();
    t_interfere();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule